// File: doc/BRIEF.md
# Strided Dependence Run Compressor

This block sits at the output of a recording path for multithreaded replay. Its input is a stream of cross-thread ordering records that are already reduced. Each record says that instruction `dst` of the local thread must wait until instruction `src` of thread `tid` has executed. The block makes one greedy, online pass over the stream and keeps a single open candidate vector. While the new records advance their source count and their destination count by one common step, it folds them into that vector. It then emits one record that carries the thread, the two start counts, the number of elements and the step. Replay rebuilds element k as the pair (src + k·step, dst + k·step).

To make a run fit, the block may raise a record's source count by up to `SLACK` instructions. The destination then waits for a later source instruction, which is a stricter ordering than required and is still correct. Any record that cannot extend the open vector closes it and starts a new one. An input flag marks records whose ordering is pinned by a store still sitting in a store buffer. Such a record never joins a vector, which shrinks the merge window as total-store-order recording requires. Vectors leave in the order their first element arrived, so the log follows the input's single total order. A flush input closes the open vector. The output is a valid/ready stream that holds its record under backpressure.

Top module: `dvc_compressor`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Records from one thread are merged into one output record when each record's destination count exceeds the previous one by the run's step and its source count equals the projected value. The step is a nonzero delta no larger than 2^DELTA_W−1, and it is set by the second element. The output record gives the first element's counts, the element count and the step.
- R3: When a record's source count is below the projected source count by at most `SLACK`, it still joins the run and is tightened to the projected count. When it is lower by more than `SLACK`, or higher than projected, it does not join.
- R4: A record that cannot extend the open vector emits that vector and opens a new one holding only itself. This covers a different thread, a step mismatch, a destination that does not advance, and a first step larger than 2^DELTA_W−1.
- R5: A vector of one element is emitted with `out_cnt` = 1 and `out_delta` = 0, which is a plain single dependence.
- R6: A vector never holds more than `MAX_RUN` elements. The record after a full run starts a new vector.
- R7: A record with `in_hold` = 1 never joins the open vector. It always starts a new one, and later records may extend that new vector.
- R8: An accepted `flush` emits the open vector, if there is one. When a record is accepted in the same cycle, the flush acts first and the record opens a fresh vector. A flush is accepted only while `in_ready` is 1.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output record stays unchanged and `in_ready` is 0. No record is lost.
- R10: Output records appear in the order in which their first elements were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input record present |
| in_ready | output | 1 | Block accepts a record or a flush this cycle |
| in_tid | input | TID_W | Source thread of the dependence |
| in_src_ic | input | IC_W | Source instruction count |
| in_dst_ic | input | IC_W | Destination instruction count |
| in_hold | input | 1 | Ordering pinned by a buffered store; do not merge |
| flush | input | 1 | Close and emit the open vector |
| out_valid | output | 1 | Output record present |
| out_ready | input | 1 | Consumer takes the output record |
| out_tid | output | TID_W | Source thread of the vector |
| out_src_ic | output | IC_W | Source count of the first element |
| out_dst_ic | output | IC_W | Destination count of the first element |
| out_cnt | output | CNT_W | Number of elements |
| out_delta | output | DELTA_W | Step of both counts; 0 for a single |

## Verification
A flush and an arriving record can be accepted in the same cycle. That record could also be a legal extension of the open vector, so the block has to choose between merging it and closing the vector. The bench builds a two-element run and then raises `flush` together with the record that would be the third element. The expected output is the two-element vector, followed later by the third record as a single. A merged three-element vector counts as a failure.

// File: rtl/dvc_pkg.sv
// Shared widths and record types of the dependence run compressor.
// Assumes IC_W > DELTA_W.
package dvc_pkg;
    parameter int TID_W   = 2;
    parameter int IC_W    = 16;
    parameter int CNT_W   = 5;
    parameter int DELTA_W = 8;

    // One reduced dependence as it arrives.
    typedef struct packed {
        logic [TID_W-1:0]   tid;
        logic [IC_W-1:0]    src;
        logic [IC_W-1:0]    dst;
        logic               hold;
    } dep_rec_t;

    // The open candidate vector, with its last (possibly tightened) element.
    typedef struct packed {
        logic [TID_W-1:0]   tid;
        logic [IC_W-1:0]    src_start;
        logic [IC_W-1:0]    dst_start;
        logic [IC_W-1:0]    src_last;
        logic [IC_W-1:0]    dst_last;
        logic [CNT_W-1:0]   cnt;
        logic [DELTA_W-1:0] delta;
    } open_vec_t;

    // One emitted vector record.
    typedef struct packed {
        logic [TID_W-1:0]   tid;
        logic [IC_W-1:0]    src;
        logic [IC_W-1:0]    dst;
        logic [CNT_W-1:0]   cnt;
        logic [DELTA_W-1:0] delta;
    } vec_rec_t;
endpackage

// File: rtl/dvc_merge_logic.sv
// Combinational decision: can the incoming record extend the open vector?
// It projects the next element from the run's step. It accepts a source
// count that lies at most SLACK below the projection, and then tightens
// the source count to the projection. Assumes the counts do not wrap
// inside one run.
module dvc_merge_logic
    import dvc_pkg::*;
#(
    parameter int MAX_RUN = 8,
    parameter int SLACK   = 2
) (
    input  open_vec_t          ov,
    input  logic               ov_valid,
    input  dep_rec_t           rec,
    output logic               can_merge,
    output logic [IC_W-1:0]    tight_src,
    output logic [DELTA_W-1:0] next_delta
);
    localparam int DELTA_MAX = (1 << DELTA_W) - 1;

    logic              first_step;
    logic [IC_W:0]     d_step;
    logic [IC_W-1:0]   step;
    logic              dst_ok;
    logic [IC_W:0]     s_exp;
    logic [IC_W+1:0]   gap;
    logic              src_ok;

    // Derive the step, check the destination, project and compare the source.
    always_comb begin
        first_step = (ov.cnt == CNT_W'(1));
        d_step     = {1'b0, rec.dst} - {1'b0, ov.dst_last};
        if (first_step) begin
            step   = d_step[IC_W-1:0];
            dst_ok = !d_step[IC_W] && (d_step != '0) &&
                     (d_step <= (IC_W+1)'(DELTA_MAX));
        end else begin
            step   = {{(IC_W-DELTA_W){1'b0}}, ov.delta};
            dst_ok = (rec.dst == ov.dst_last + step);
        end
        s_exp      = {1'b0, ov.src_last} + {1'b0, step};
        gap        = {1'b0, s_exp} - {2'b00, rec.src};
        src_ok     = !s_exp[IC_W] && !gap[IC_W+1] &&
                     (gap <= (IC_W+2)'(SLACK));
        tight_src  = s_exp[IC_W-1:0];
        next_delta = first_step ? d_step[DELTA_W-1:0] : ov.delta;
        can_merge  = ov_valid && (rec.tid == ov.tid) && !rec.hold &&
                     (ov.cnt < CNT_W'(MAX_RUN)) && dst_ok && src_ok;
    end
endmodule

// File: rtl/dvc_open_vec.sv
// Register that holds the single open candidate vector. Starting a new
// vector has priority over extending it, and extending has priority
// over clearing it.
module dvc_open_vec
    import dvc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_new,
    input  logic               extend,
    input  logic               clear,
    input  dep_rec_t           rec,
    input  logic [IC_W-1:0]    tight_src,
    input  logic [DELTA_W-1:0] next_delta,
    output open_vec_t          ov,
    output logic               ov_valid
);
    // Update the open vector from the control decision of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_valid <= 1'b0;
            ov       <= '0;
        end else if (start_new) begin
            ov_valid     <= 1'b1;
            ov.tid       <= rec.tid;
            ov.src_start <= rec.src;
            ov.dst_start <= rec.dst;
            ov.src_last  <= rec.src;
            ov.dst_last  <= rec.dst;
            ov.cnt       <= CNT_W'(1);
            ov.delta     <= '0;
        end else if (extend) begin
            ov.src_last <= tight_src;
            ov.dst_last <= rec.dst;
            ov.cnt      <= ov.cnt + CNT_W'(1);
            ov.delta    <= next_delta;
        end else if (clear) begin
            ov_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dvc_out_slot.sv
// One-entry output register with a valid/ready handshake. It is loaded
// only when it is empty or is being drained in the same cycle, and it
// holds its record while the consumer stalls.
module dvc_out_slot
    import dvc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  vec_rec_t load_data,
    input  logic     out_ready,
    output logic     out_valid,
    output vec_rec_t out_data,
    output logic     free
);
    // The slot can take a record when it is empty or draining now.
    assign free = !out_valid || out_ready;

    // Load a new record, or drop the record that was taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dvc_compressor.sv
// Top module of the strided dependence run compressor. It accepts a
// record and/or a flush when the output slot can take a closed vector.
// Assumes the input records are already reduced and arrive in the
// destination thread's total order.
module dvc_compressor
    import dvc_pkg::*;
#(
    parameter int MAX_RUN = 8,
    parameter int SLACK   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [TID_W-1:0]   in_tid,
    input  logic [IC_W-1:0]    in_src_ic,
    input  logic [IC_W-1:0]    in_dst_ic,
    input  logic               in_hold,
    input  logic               flush,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [TID_W-1:0]   out_tid,
    output logic [IC_W-1:0]    out_src_ic,
    output logic [IC_W-1:0]    out_dst_ic,
    output logic [CNT_W-1:0]   out_cnt,
    output logic [DELTA_W-1:0] out_delta
);
    dep_rec_t           rec;
    open_vec_t          ov;
    logic               ov_valid;
    logic               can_merge;
    logic [IC_W-1:0]    tight_src;
    logic [DELTA_W-1:0] next_delta;
    logic               slot_free;
    logic               acc_in, acc_fl;
    logic               extend, start_new, clear, emit;
    vec_rec_t           emit_data;
    vec_rec_t           out_data;

    // Pack the input pins into one record.
    always_comb begin
        rec.tid  = in_tid;
        rec.src  = in_src_ic;
        rec.dst  = in_dst_ic;
        rec.hold = in_hold;
    end

    dvc_merge_logic #(.MAX_RUN(MAX_RUN), .SLACK(SLACK)) merge_i (
        .ov(ov), .ov_valid(ov_valid), .rec(rec), .can_merge(can_merge),
        .tight_src(tight_src), .next_delta(next_delta)
    );

    // Decide the action: extend, close and reopen, flush, or emit.
    always_comb begin
        in_ready  = slot_free;
        acc_in    = in_valid && slot_free;
        acc_fl    = flush && slot_free;
        extend    = acc_in && !acc_fl && can_merge;
        start_new = acc_in && (acc_fl || !can_merge);
        clear     = acc_fl && !acc_in;
        emit      = ov_valid && (acc_fl || (acc_in && !can_merge));
    end

    // Form the closed vector; a single element carries a zero step.
    always_comb begin
        emit_data.tid   = ov.tid;
        emit_data.src   = ov.src_start;
        emit_data.dst   = ov.dst_start;
        emit_data.cnt   = ov.cnt;
        emit_data.delta = (ov.cnt == CNT_W'(1)) ? '0 : ov.delta;
    end

    dvc_open_vec open_i (
        .clk(clk), .rst_n(rst_n), .start_new(start_new), .extend(extend),
        .clear(clear), .rec(rec), .tight_src(tight_src),
        .next_delta(next_delta), .ov(ov), .ov_valid(ov_valid)
    );

    dvc_out_slot slot_i (
        .clk(clk), .rst_n(rst_n), .load(emit), .load_data(emit_data),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .free(slot_free)
    );

    // Unpack the output record onto the pins.
    always_comb begin
        out_tid    = out_data.tid;
        out_src_ic = out_data.src;
        out_dst_ic = out_data.dst;
        out_cnt    = out_data.cnt;
        out_delta  = out_data.delta;
    end
endmodule

// File: rtl/dvc_checker.sv
// Protocol and format checks on the ports of dvc_compressor; attached by bind.
module dvc_checker
    import dvc_pkg::*;
#(
    parameter int MAX_RUN = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [TID_W-1:0]   out_tid,
    input logic [IC_W-1:0]    out_src_ic,
    input logic [IC_W-1:0]    out_dst_ic,
    input logic [CNT_W-1:0]   out_cnt,
    input logic [DELTA_W-1:0] out_delta
);
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_tid) && $stable(out_src_ic) && $stable(out_dst_ic) && $stable(out_cnt) && $stable(out_delta)); // R9
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R9
    AST_SINGLE_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_cnt == CNT_W'(1) |-> out_delta == '0); // R5
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_cnt != '0 && out_cnt <= CNT_W'(MAX_RUN)); // R6
    AST_MULTI_NONZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_cnt > CNT_W'(1) |-> out_delta != '0); // R2
endmodule

bind dvc_compressor dvc_checker #(.MAX_RUN(MAX_RUN)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_tid(out_tid), .out_src_ic(out_src_ic),
    .out_dst_ic(out_dst_ic), .out_cnt(out_cnt), .out_delta(out_delta)
);

// File: tb/dvc_compressor_tb_top.sv
// Directed bench: one task per scenario, with a scoreboard of expected vectors.
module dvc_compressor_tb_top;
    import dvc_pkg::*;

    localparam int MAX_RUN = 8;
    localparam int SLACK   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_hold = 1'b0, flush = 1'b0, out_ready = 1'b1;
    logic [TID_W-1:0] in_tid = '0;
    logic [IC_W-1:0]  in_src_ic = '0, in_dst_ic = '0;
    logic in_ready, out_valid;
    logic [TID_W-1:0] out_tid;
    logic [IC_W-1:0]  out_src_ic, out_dst_ic;
    logic [CNT_W-1:0] out_cnt;
    logic [DELTA_W-1:0] out_delta;

    int n_chk = 0, n_fail = 0;
    vec_rec_t exp_q[$];
    string    tag_q[$];

    dvc_compressor #(.MAX_RUN(MAX_RUN), .SLACK(SLACK)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tid(in_tid), .in_src_ic(in_src_ic), .in_dst_ic(in_dst_ic),
        .in_hold(in_hold), .flush(flush), .out_valid(out_valid),
        .out_ready(out_ready), .out_tid(out_tid), .out_src_ic(out_src_ic),
        .out_dst_ic(out_dst_ic), .out_cnt(out_cnt), .out_delta(out_delta)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic expect_vec(input int t, input int s, input int d,
                              input int c, input int dl, input string req);
        vec_rec_t v;
        v.tid = TID_W'(t); v.src = IC_W'(s); v.dst = IC_W'(d);
        v.cnt = CNT_W'(c); v.delta = DELTA_W'(dl);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    // Monitor: compare every handshaken output with the next expected one.
    always @(negedge clk) begin
        #5;
        if (rst_n && out_valid && out_ready) begin
            vec_rec_t got;
            got = {out_tid, out_src_ic, out_dst_ic, out_cnt, out_delta};
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", $sformatf("unexpected record act t%0d s%0d d%0d n%0d dl%0d exp none",
                      got.tid, got.src, got.dst, got.cnt, got.delta));
            end else begin
                vec_rec_t e;
                string r;
                e = exp_q.pop_front();
                r = tag_q.pop_front();
                check(got == e, r, $sformatf("act t%0d s%0d d%0d n%0d dl%0d exp t%0d s%0d d%0d n%0d dl%0d",
                      got.tid, got.src, got.dst, got.cnt, got.delta,
                      e.tid, e.src, e.dst, e.cnt, e.delta));
            end
        end
    end

    // Present one record (and optionally a flush) until it is accepted.
    task automatic send(input int t, input int s, input int d, input bit h,
                        input bit valid, input bit fl);
        bit ok;
        in_tid = TID_W'(t); in_src_ic = IC_W'(s); in_dst_ic = IC_W'(d);
        in_hold = h; in_valid = valid; flush = fl;
        ok = 1'b0;
        while (!ok) begin
            #5;
            ok = in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0; flush = 1'b0; in_hold = 1'b0;
    endtask

    task automatic rec(input int t, input int s, input int d);
        send(t, s, d, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic do_flush();
        send(0, 0, 0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic drain(input string req);
        out_ready = 1'b1;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, req, $sformatf("missing records act %0d exp 0", exp_q.size()));
    endtask

    task automatic t_reset();
        #5;
        check(out_valid == 1'b0, "R1", $sformatf("out_valid act %0b exp 0", out_valid));
        check(in_ready == 1'b1, "R1", $sformatf("in_ready act %0b exp 1", in_ready));
        @(negedge clk);
    endtask

    task automatic t_unit_run();
        expect_vec(1, 3, 5, 3, 1, "R2");
        rec(1, 3, 5); rec(1, 4, 6); rec(1, 5, 7);
        do_flush();
        drain("R2");
    endtask

    task automatic t_tighten();
        expect_vec(0, 10, 20, 4, 3, "R3");
        expect_vec(0, 19, 32, 1, 0, "R3");
        expect_vec(0, 25, 35, 1, 0, "R5");
        rec(0, 10, 20); rec(0, 13, 23);
        rec(0, 14, 26);
        rec(0, 19, 29);
        rec(0, 19, 32);
        rec(0, 25, 35);
        do_flush();
        drain("R3");
    endtask

    task automatic t_break();
        expect_vec(2, 1, 1, 2, 1, "R4");
        expect_vec(2, 3, 4, 1, 0, "R4");
        expect_vec(2, 4, 4, 1, 0, "R4");
        expect_vec(2, 300, 300, 1, 0, "R4");
        rec(2, 1, 1); rec(2, 2, 2); rec(2, 3, 4); rec(2, 4, 4);
        rec(2, 300, 300);
        do_flush();
        drain("R4");
    endtask

    task automatic t_thread_change();
        expect_vec(1, 50, 60, 2, 1, "R4");
        expect_vec(3, 52, 62, 1, 0, "R10");
        rec(1, 50, 60); rec(1, 51, 61); rec(3, 52, 62);
        do_flush();
        drain("R10");
    endtask

    task automatic t_hold();
        expect_vec(0, 70, 80, 1, 0, "R7");
        expect_vec(0, 71, 81, 2, 1, "R7");
        rec(0, 70, 80);
        send(0, 71, 81, 1'b1, 1'b1, 1'b0);
        rec(0, 72, 82);
        do_flush();
        drain("R7");
    endtask

    task automatic t_cap();
        expect_vec(1, 100, 200, MAX_RUN, 1, "R6");
        expect_vec(1, 100 + MAX_RUN, 200 + MAX_RUN, 1, 0, "R6");
        for (int i = 0; i <= MAX_RUN; i++) rec(1, 100 + i, 200 + i);
        do_flush();
        drain("R6");
    endtask

    task automatic t_backpressure();
        expect_vec(0, 1, 1, 1, 0, "R9");
        expect_vec(1, 1, 1, 1, 0, "R9");
        expect_vec(2, 1, 1, 1, 0, "R9");
        out_ready = 1'b0;
        rec(0, 1, 1); rec(1, 1, 1);
        in_tid = 2'd2; in_src_ic = 16'd1; in_dst_ic = 16'd1; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        #5;
        check(in_ready == 1'b0, "R9", $sformatf("in_ready act %0b exp 0", in_ready));
        check(out_valid && out_tid == 2'd0 && out_src_ic == 16'd1, "R9",
              $sformatf("held record act v%0b t%0d s%0d exp v1 t0 s1", out_valid, out_tid, out_src_ic));
        @(negedge clk);
        out_ready = 1'b1;
        send(2, 1, 1, 1'b0, 1'b1, 1'b0);
        do_flush();
        drain("R9");
    endtask

    task automatic t_flush_collide();
        expect_vec(1, 5, 5, 2, 1, "R8");
        expect_vec(1, 7, 7, 1, 0, "R8");
        rec(1, 5, 5); rec(1, 6, 6);
        send(1, 7, 7, 1'b0, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        do_flush();
        drain("R8");
    endtask

    initial begin
        #(200000 * 20);
        check(1'b0, "WATCHDOG", "run hung act running exp done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unit_run();
        t_tighten();
        t_break();
        t_thread_change();
        t_hold();
        t_cap();
        t_backpressure();
        t_flush_collide();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule